// File: doc/BRIEF.md
# UART Receive Character Queue with Automatic Flow Control

This block is the buffering stage behind a UART receiver. The receive shift register hands it finished characters. Each character arrives with three error tags. The block keeps the characters in a first-in first-out queue and presents the oldest one, together with its tags, to the host. The host consumes characters one at a time with a read strobe, and it clears a sticky overrun flag with a separate status-read strobe.

Two interrupt requests are produced, and both are gated by one enable input:
- A fill-level request fires once the queue holds at least the programmed trigger count.
- An idle-line request fires when no character has arrived and no read has happened for four character times plus twelve bit times, while data is still waiting.

When automatic flow control is switched on, the active-low ready-to-send output is driven from the fill level with a hysteresis band around the trigger. This pauses the far transmitter before the queue overflows and restarts it once the queue has drained. With the queue switched off, the block acts as a single holding register.

Top module: `uart_rx_buffer`

## Requirements
- R1: Characters leave in arrival order. While the queue is not empty, `rd_data` and `rd_tag` show the oldest stored character and its tags. One cycle after a `rd_strb` they show the next character.
- R2: With `fifo_en`=1 the queue holds DEPTH characters, and `fill` equals the number of stored characters one cycle after each accepted write or read.
- R3: A `wr_vld` that arrives while the queue is at capacity is discarded and sets `overrun`. `overrun` stays set until the cycle after a `stat_rd` pulse.
- R4: With `fifo_en`=0 the capacity is one character and the effective trigger is 1.
- R5: A one-cycle `fifo_rst` pulse, or any change of `fifo_en`, empties the queue within one cycle.
- R6: `irq_data` = `rdy_ie` AND (`fill` >= effective trigger). The effective trigger is `trig_lvl` clamped to the range 1 to capacity, where capacity is DEPTH with the queue on and 1 with it off.
- R7: A bit time is 16 `samp_tick` pulses when `os_sel`=0 and 8 when `os_sel`=1. `wlen` values 0 to 3 mean 5 to 8 data bits, and a character time is 7+`wlen` bits. The idle request is raised after exactly 4*(7+`wlen`)+12 bit times.
- R8: The idle timer restarts on every `wr_vld` and every `rd_strb`. `irq_tmo` asserts only while data is stored and only with `rdy_ie`=1. It clears one cycle after `rd_strb`.
- R9: With automatic flow control active, `rts_n` goes to 1 one cycle after `fill` reaches the upper threshold, min(trigger+HYST, capacity). It returns to 0 one cycle after `fill` reaches the lower threshold, trigger-HYST (floored at 0). Between the two thresholds it holds its level.
- R10: Automatic flow control is active only when both `afc_en` and `mcr_rts` are 1. Otherwise `rts_n` = NOT `mcr_rts`.
- R11: A queue flush while automatic flow control is active returns `rts_n` to 0 and clears a pending idle request.
- R12: A `rd_strb` on an empty queue has no effect, and while the queue is empty `rd_data` and `rd_tag` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single holding register |
| fifo_rst | input | 1 | One-cycle strobe that empties the queue |
| trig_lvl | input | clog2(DEPTH+1) | Programmed fill trigger |
| rdy_ie | input | 1 | Enable for both interrupt requests |
| wlen | input | 2 | Data bits per character minus 5 |
| os_sel | input | 1 | 0 selects 16 sample ticks per bit, 1 selects 8 |
| samp_tick | input | 1 | Oversampling clock enable |
| afc_en | input | 1 | Enable for automatic flow control |
| mcr_rts | input | 1 | Host ready-to-send request bit |
| wr_vld | input | 1 | Character strobe from the shift register |
| wr_data | input | DATA_W | Received character |
| wr_tag | input | TAG_W | Error tags of the received character |
| rd_strb | input | 1 | Host consumes the head character |
| stat_rd | input | 1 | Host status read, clears overrun |
| rd_data | output | DATA_W | Head character |
| rd_tag | output | TAG_W | Error tags of the head character |
| data_rdy | output | 1 | Queue is not empty |
| fill | output | clog2(DEPTH+1) | Number of stored characters |
| overrun | output | 1 | Sticky flag for a discarded character |
| irq_data | output | 1 | Fill-level interrupt request |
| irq_tmo | output | 1 | Idle-line interrupt request |
| rts_n | output | 1 | Ready-to-send, active low |

## Verification
The bench builds the block with DEPTH=8 and HYST=2. At that size every fill level from empty to full can be walked in both directions for all sixteen `trig_lvl` codes. This covers the trigger clamps at 0 and above capacity, the upper threshold clipped at capacity, and the lower threshold floored at zero. The short queue also makes the overrun and holding-register modes easy to reach. The idle timer does not depend on DEPTH, so all eight combinations of word length and oversampling ratio are swept to the exact tick that triggers the request, with one tick fewer checked as the negative case.

// File: rtl/rxbuf_pkg.sv
`timescale 1ns/1ps
package rxbuf_pkg;

    // Sample ticks per bit, minus one.
    localparam logic [3:0] SAMP_X16_M1 = 4'd15;
    localparam logic [3:0] SAMP_X8_M1  = 4'd7;

    // Widest idle limit: 4 * (7 + 3) + 12 = 52 bit times.
    localparam int unsigned IDLE_MAX = 52;
    localparam int unsigned IDLE_W   = $clog2(IDLE_MAX + 1);

    // Bit times of silence before the idle request, for a word-length code.
    function automatic logic [IDLE_W-1:0] idle_limit(input logic [1:0] wl);
        logic [IDLE_W-1:0] char_bits;
        char_bits  = IDLE_W'(7) + IDLE_W'(wl);
        idle_limit = (char_bits << 2) + IDLE_W'(12);
    endfunction

endpackage

// File: rtl/rxbuf_store.sv
`timescale 1ns/1ps
module rxbuf_store #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cap_one,
    input  logic              wr_vld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              rd_strb,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic [LVL_W-1:0]  level,
    output logic              overrun
);
    // DEPTH must be a power of two so that the pointers wrap naturally.
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned ENT_W = DATA_W + TAG_W;

    typedef logic [ENT_W-1:0] entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   wptr;
        logic [PTR_W-1:0]   rptr;
        logic [LVL_W-1:0]   lvl;
        logic               ovr;
    } store_t;

    store_t st_d, st_q;
    logic [LVL_W-1:0] cap;
    logic             full, empty, push, pop;

    always_comb begin
        cap   = cap_one ? LVL_W'(1) : LVL_W'(DEPTH);
        full  = (st_q.lvl >= cap);
        empty = (st_q.lvl == '0);
        push  = wr_vld && !full;
        pop   = rd_strb && !empty;

        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wptr] = {wr_tag, wr_data};
            st_d.wptr           = st_q.wptr + PTR_W'(1);
        end
        if (pop) begin
            st_d.rptr = st_q.rptr + PTR_W'(1);
        end
        st_d.lvl = st_q.lvl + LVL_W'(push) - LVL_W'(pop);

        if (stat_rd) begin
            st_d.ovr = 1'b0;
        end
        if (wr_vld && full) begin
            st_d.ovr = 1'b1;
        end

        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.lvl  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (empty) begin
            {head_tag, head_data} = '0;
        end else begin
            {head_tag, head_data} = st_q.mem[st_q.rptr];
        end
    end

    assign level   = st_q.lvl;
    assign overrun = st_q.ovr;

endmodule

// File: rtl/rxbuf_idle.sv
`timescale 1ns/1ps
module rxbuf_idle
    import rxbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       restart,
    input  logic       clr,
    input  logic       samp_tick,
    input  logic       os_sel,
    input  logic [1:0] wlen,
    input  logic       nonempty,
    output logic       tmo
);
    typedef struct packed {
        logic [3:0]        sc;
        logic [IDLE_W-1:0] bc;
        logic              tmo;
    } idle_t;

    idle_t id_d, id_q;
    logic [3:0]        ratio_m1;
    logic [IDLE_W-1:0] limit;

    always_comb begin
        ratio_m1 = os_sel ? SAMP_X8_M1 : SAMP_X16_M1;
        limit    = idle_limit(wlen);

        id_d = id_q;
        if (samp_tick) begin
            if (id_q.sc == ratio_m1) begin
                id_d.sc = '0;
                if (id_q.bc < limit) begin
                    id_d.bc = id_q.bc + IDLE_W'(1);
                end
            end else begin
                id_d.sc = id_q.sc + 4'd1;
            end
        end
        if (id_q.bc == limit && nonempty) begin
            id_d.tmo = 1'b1;
        end
        if (restart || flush) begin
            id_d.sc = '0;
            id_d.bc = '0;
        end
        if (clr || flush) begin
            id_d.tmo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q <= '0;
        end else begin
            id_q <= id_d;
        end
    end

    assign tmo = id_q.tmo;

endmodule

// File: rtl/rxbuf_flow.sv
`timescale 1ns/1ps
module rxbuf_flow #(
    parameter int unsigned LVL_W = 7,
    parameter int unsigned HYST  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig_raw,
    input  logic [LVL_W-1:0] cap,
    input  logic             afc_en,
    input  logic             mcr_rts,
    output logic             trig_hit,
    output logic             rts_n
);
    typedef struct packed {
        logic pause;
    } flow_t;

    flow_t fl_d, fl_q;
    logic [LVL_W-1:0] teff, hi, lo;
    logic [LVL_W:0]   sum;
    logic             active;

    always_comb begin
        if (trig_raw == '0) begin
            teff = LVL_W'(1);
        end else if (trig_raw > cap) begin
            teff = cap;
        end else begin
            teff = trig_raw;
        end

        sum = {1'b0, teff} + (LVL_W + 1)'(HYST);
        hi  = (sum > {1'b0, cap}) ? cap : sum[LVL_W-1:0];
        lo  = (teff > LVL_W'(HYST)) ? (teff - LVL_W'(HYST)) : '0;

        active = afc_en && mcr_rts;

        fl_d = fl_q;
        if (!active || flush) begin
            fl_d.pause = 1'b0;
        end else if (level >= hi) begin
            fl_d.pause = 1'b1;
        end else if (level <= lo) begin
            fl_d.pause = 1'b0;
        end

        trig_hit = (level >= teff);
        rts_n    = active ? fl_q.pause : !mcr_rts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

endmodule

// File: rtl/uart_rx_buffer.sv
`timescale 1ns/1ps
module uart_rx_buffer #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned HYST   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_en,
    input  logic                         fifo_rst,
    input  logic [$clog2(DEPTH+1)-1:0]   trig_lvl,
    input  logic                         rdy_ie,
    input  logic [1:0]                   wlen,
    input  logic                         os_sel,
    input  logic                         samp_tick,
    input  logic                         afc_en,
    input  logic                         mcr_rts,
    input  logic                         wr_vld,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic                         rd_strb,
    input  logic                         stat_rd,
    output logic [DATA_W-1:0]            rd_data,
    output logic [TAG_W-1:0]             rd_tag,
    output logic                         data_rdy,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         overrun,
    output logic                         irq_data,
    output logic                         irq_tmo,
    output logic                         rts_n
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic en_seen;
    } top_t;

    top_t tp_d, tp_q;
    logic             flush;
    logic [LVL_W-1:0] cap;
    logic [LVL_W-1:0] level;
    logic             trig_hit;
    logic             tmo;

    always_comb begin
        tp_d         = tp_q;
        tp_d.en_seen = fifo_en;
        flush        = fifo_rst || (fifo_en != tp_q.en_seen);
        cap          = fifo_en ? LVL_W'(DEPTH) : LVL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= '0;
        end else begin
            tp_q <= tp_d;
        end
    end

    rxbuf_store #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .TAG_W (TAG_W),
        .LVL_W (LVL_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .cap_one  (!fifo_en),
        .wr_vld   (wr_vld),
        .wr_data  (wr_data),
        .wr_tag   (wr_tag),
        .rd_strb  (rd_strb),
        .stat_rd  (stat_rd),
        .head_data(rd_data),
        .head_tag (rd_tag),
        .level    (level),
        .overrun  (overrun)
    );

    rxbuf_idle u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .restart  (wr_vld || rd_strb),
        .clr      (rd_strb),
        .samp_tick(samp_tick),
        .os_sel   (os_sel),
        .wlen     (wlen),
        .nonempty (level != '0),
        .tmo      (tmo)
    );

    rxbuf_flow #(
        .LVL_W(LVL_W),
        .HYST (HYST)
    ) u_flow (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .level   (level),
        .trig_raw(trig_lvl),
        .cap     (cap),
        .afc_en  (afc_en),
        .mcr_rts (mcr_rts),
        .trig_hit(trig_hit),
        .rts_n   (rts_n)
    );

    assign fill     = level;
    assign data_rdy = (level != '0);
    assign irq_data = rdy_ie && trig_hit;
    assign irq_tmo  = rdy_ie && tmo;

endmodule

// File: rtl/rxbuf_chk.sv
`timescale 1ns/1ps
module rxbuf_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          fifo_rst,
    input logic          rd_strb,
    input logic          wr_vld,
    input logic          stat_rd,
    input logic          rdy_ie,
    input logic          afc_en,
    input logic          mcr_rts,
    input logic          data_rdy,
    input logic          overrun,
    input logic          irq_data,
    input logic          irq_tmo,
    input logic          rts_n,
    input logic [LW-1:0] fill
);
    // R2
    fill_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= LW'(DEPTH));

    // R1
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strb && data_rdy && !wr_vld && !fifo_rst && $stable(fifo_en))
        |=> (fill == $past(fill) - LW'(1)));

    // R3
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun);

    // R3
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !wr_vld) |=> !overrun);

    // R5
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |=> (fill == '0));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_ie |-> (!irq_data && !irq_tmo));

    // R8
    tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tmo |-> data_rdy);

    // R8
    tmo_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strb |=> !irq_tmo);

    // R10
    manual_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(afc_en && mcr_rts) |-> (rts_n == !mcr_rts));

    // R11
    flush_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rst && afc_en && mcr_rts) |=> (!rts_n || !(afc_en && mcr_rts)));

endmodule

bind uart_rx_buffer rxbuf_chk #(
    .DEPTH(DEPTH),
    .LW   (LVL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .fifo_rst(fifo_rst),
    .rd_strb (rd_strb),
    .wr_vld  (wr_vld),
    .stat_rd (stat_rd),
    .rdy_ie  (rdy_ie),
    .afc_en  (afc_en),
    .mcr_rts (mcr_rts),
    .data_rdy(data_rdy),
    .overrun (overrun),
    .irq_data(irq_data),
    .irq_tmo (irq_tmo),
    .rts_n   (rts_n),
    .fill    (fill)
);

// File: tb/test_uart_rx_buffer.sv
`timescale 1ns/1ps
module test_uart_rx_buffer;
    localparam int DEPTH = 8;
    localparam int HYST  = 2;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b1, fifo_rst = 1'b0;
    logic [LW-1:0] trig_lvl = LW'(4);
    logic          rdy_ie = 1'b1;
    logic [1:0]    wlen = 2'd3;
    logic          os_sel = 1'b0, samp_tick = 1'b0;
    logic          afc_en = 1'b1, mcr_rts = 1'b1;
    logic          wr_vld = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [2:0]    wr_tag = '0;
    logic          rd_strb = 1'b0, stat_rd = 1'b0;
    logic [7:0]    rd_data;
    logic [2:0]    rd_tag;
    logic          data_rdy, overrun, irq_data, irq_tmo, rts_n;
    logic [LW-1:0] fill;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    uart_rx_buffer #(.DEPTH(DEPTH), .DATA_W(8), .TAG_W(3), .HYST(HYST)) i_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_rst(fifo_rst),
        .trig_lvl(trig_lvl), .rdy_ie(rdy_ie), .wlen(wlen), .os_sel(os_sel),
        .samp_tick(samp_tick), .afc_en(afc_en), .mcr_rts(mcr_rts),
        .wr_vld(wr_vld), .wr_data(wr_data), .wr_tag(wr_tag),
        .rd_strb(rd_strb), .stat_rd(stat_rd), .rd_data(rd_data), .rd_tag(rd_tag),
        .data_rdy(data_rdy), .fill(fill), .overrun(overrun),
        .irq_data(irq_data), .irq_tmo(irq_tmo), .rts_n(rts_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] t);
        wr_vld = 1'b1; wr_data = d; wr_tag = t;
        @(negedge clk);
        wr_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop();
        rd_strb = 1'b1;
        @(negedge clk);
        rd_strb = 1'b0;
        @(negedge clk);
    endtask

    task automatic flush();
        fifo_rst = 1'b1;
        @(negedge clk);
        fifo_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            samp_tick = 1'b1;
            repeat (n) @(negedge clk);
            samp_tick = 1'b0;
        end
        idle(2);
    endtask

    function automatic int eff_trig(input int t, input int cap);
        if (t == 0) return 1;
        if (t > cap) return cap;
        return t;
    endfunction

    // Bench model of the hysteresis band (R9)
    function automatic bit next_pause(input bit p, input int lvl, input int trg, input int cap);
        int hi, lo;
        hi = (trg + HYST > cap) ? cap : trg + HYST;
        lo = (trg > HYST) ? trg - HYST : 0;
        if (lvl >= hi) return 1'b1;
        if (lvl <= lo) return 1'b0;
        return p;
    endfunction

    task automatic idle_case(input logic [1:0] wl, input logic os);
        int n;
        wlen = wl; os_sel = os;
        n = (4 * (7 + int'(wl)) + 12) * (os ? 8 : 16);
        flush();
        ticks(n + 4);
        chk("R8 no idle request while empty", irq_tmo, 0);
        push(8'h55, 3'd0);
        ticks(n - 1);
        chk("R7 idle one tick early", irq_tmo, 0);
        ticks(1);
        chk("R7 idle at limit", irq_tmo, 1);
        pop();
        chk("R8 idle cleared by read", irq_tmo, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit p;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R2 reset fill", int'(fill), 0);
        chk("R12 reset rd_data", int'(rd_data), 0);
        chk("R3 reset overrun", overrun, 0);
        chk("R6 reset irq_data", irq_data, 0);
        chk("R9 reset rts_n", rts_n, 0);

        // Order, tags, capacity, overrun
        trig_lvl = LW'(4);
        for (int i = 0; i < DEPTH; i++) begin
            push(8'hA0 + 8'(i), 3'(i));
            chk("R2 fill count", int'(fill), i + 1);
        end
        push(8'hEE, 3'd7);
        chk("R3 overrun fill held", int'(fill), DEPTH);
        chk("R3 overrun set", overrun, 1);
        chk("R3 head kept", int'(rd_data), 'hA0);
        idle(3);
        chk("R3 overrun sticky", overrun, 1);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
        chk("R3 overrun cleared", overrun, 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R1 head data", int'(rd_data), 'hA0 + i);
            chk("R1 head tag", int'(rd_tag), i);
            pop();
        end
        chk("R12 empty rd_data", int'(rd_data), 0);
        chk("R12 empty rd_tag", int'(rd_tag), 0);
        pop();
        chk("R12 read on empty", int'(fill), 0);
        push(8'h3C, 3'd5);
        chk("R12 no pointer drift", int'(rd_data), 'h3C);
        chk("R1 tag after refill", int'(rd_tag), 5);
        flush();
        chk("R5 flush empties", int'(fill), 0);

        // Trigger and hysteresis sweep over all trigger codes
        for (int t = 0; t < (1 << LW); t++) begin
            int te;
            trig_lvl = LW'(t);
            te = eff_trig(t, DEPTH);
            flush();
            p = 1'b0;
            for (int k = 1; k <= DEPTH; k++) begin
                push(8'(k), 3'd0);
                p = next_pause(p, k, te, DEPTH);
                chk("R6 irq_data rising", irq_data, int'(k >= te));
                chk("R9 rts_n rising", rts_n, int'(p));
            end
            rdy_ie = 1'b0; @(negedge clk);
            chk("R6 gated by rdy_ie", irq_data, 0);
            rdy_ie = 1'b1;
            for (int k = DEPTH - 1; k >= 0; k--) begin
                pop();
                p = next_pause(p, k, te, DEPTH);
                chk("R6 irq_data falling", irq_data, int'(k >= te));
                chk("R9 rts_n falling", rts_n, int'(p));
            end
        end

        // Manual ready-to-send and flush release
        trig_lvl = LW'(4);
        for (int k = 0; k < DEPTH; k++) push(8'(k), 3'd0);
        chk("R9 full pauses", rts_n, 1);
        afc_en = 1'b0; mcr_rts = 1'b1; idle(2);
        chk("R10 manual rts on", rts_n, 0);
        mcr_rts = 1'b0; idle(2);
        chk("R10 manual rts off", rts_n, 1);
        afc_en = 1'b1; idle(2);
        chk("R10 needs mcr_rts", rts_n, 1);
        mcr_rts = 1'b1; idle(2);
        chk("R9 auto resumes pause", rts_n, 1);
        flush();
        chk("R11 flush releases rts_n", rts_n, 0);
        chk("R11 flush empties", int'(fill), 0);

        // Holding-register mode
        fifo_en = 1'b0; idle(2);
        push(8'h11, 3'd1);
        chk("R4 holds one", int'(fill), 1);
        chk("R4 trigger one", irq_data, 1);
        chk("R9 holding pause", rts_n, 1);
        push(8'h22, 3'd2);
        chk("R4 second discarded", int'(fill), 1);
        chk("R4 overrun", overrun, 1);
        chk("R4 first kept", int'(rd_data), 'h11);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        pop();
        chk("R4 empty after read", int'(fill), 0);
        push(8'h33, 3'd3);
        fifo_en = 1'b1; idle(2);
        chk("R5 mode change empties", int'(fill), 0);

        // Idle timer sweep
        for (int w = 0; w < 4; w++)
            for (int o = 0; o < 2; o++)
                idle_case(2'(w), 1'(o));

        // Restart on read
        wlen = 2'd0; os_sel = 1'b1;
        flush();
        push(8'h01, 3'd0);
        push(8'h02, 3'd0);
        ticks(40 * 8 - 1);
        pop();
        ticks(40 * 8 - 1);
        chk("R8 read restarts timer", irq_tmo, 0);
        ticks(1);
        chk("R8 fires after restart", irq_tmo, 1);
        flush();
        chk("R11 flush clears idle", irq_tmo, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule